// File: doc/BRIEF.md
# Packet-Routing Stream Switch Port Handler

This block sits at the slave side of a 32-bit streaming crossbar whose ports run in packet mode. Every packet on an input is one header beat followed by any number of data beats, the final beat flagged by `s_last`. When a header reaches the front of an input's small buffer, its parity is checked and its 5-bit stream ID indexes a route table, supplied as a static input vector, that gives a bitmask of destination outputs. The header and every following beat are then forwarded, unchanged, to every output in that mask.

Several inputs may compete for the same output. Each output serves one packet at a time and stays with it until its final beat. A packet bound for several outputs only starts once it holds all of them, and each beat is retired from the input buffer only after every destination has taken it, so a single slow destination holds back the whole group. Headers with bad parity, and stream IDs whose route mask is empty, cause the whole packet to be discarded.

Top module: `pkt_port_switch`

## Requirements
- R1: A header beat carries odd parity over all 32 bits (bit 31 is the parity bit) and a stream ID in bits [4:0]. The destination mask for ID `n` is `route_tbl[n*N_OUT +: N_OUT]`, bit `j` selecting output `j`. The header is delivered unchanged on every selected output.
- R2: After the header, every beat of the packet is delivered on each selected output in arrival order with unchanged data. `m_last` is high on the final beat only.
- R3: For a multi-destination packet, each beat is delivered exactly once per destination. The next beat is not offered to any destination until all of them have accepted the current one, so a stalled destination limits the others to the beat in progress.
- R4: A header that fails the odd-parity check is discarded together with the rest of its packet up to and including the `s_last` beat. This includes a header that is itself the last beat. `err[i]` for that input is set and stays set until reset.
- R5: A packet whose stream ID maps to an all-zero mask is discarded through its last beat without setting `err`. The packet that follows it on the same input is routed normally.
- R6: An output carries one packet at a time. Once a packet's header has been accepted on an output, no beat from another input appears there until that packet's last beat.
- R7: Inputs waiting for the same output are served round-robin. While two inputs both have packets pending for an output, the output alternates between them.
- R8: Each input buffers at most four beats. With its packet blocked, an input accepts exactly four beats and then holds `s_ready` low.
- R9: While `m_valid[j]` is high and `m_ready[j]` is low, the output keeps `m_valid`, `m_data` and `m_last` unchanged in the next cycle.
- R10: After reset no output is valid, `err` is clear and every `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_tbl | input | 32*N_OUT | Destination mask per stream ID, N_OUT bits per ID |
| s_valid | input | N_IN | Input beat valid, one bit per input |
| s_ready | output | N_IN | Input can take a beat |
| s_data | input | 32*N_IN | Input beat data, 32 bits per input |
| s_last | input | N_IN | Final beat of the packet |
| m_valid | output | N_OUT | Output beat valid |
| m_ready | input | N_OUT | Output destination takes the beat |
| m_data | output | 32*N_OUT | Output beat data |
| m_last | output | N_OUT | Final beat on this output |
| err | output | N_IN | Sticky header parity error per input |

## Verification
The hardest condition to reach is a multi-destination packet with one destination taking the beat while another refuses it. The bench reaches it in two ways. First, it holds one output's ready low while the other output stays ready, and counts that only the header gets through. Second, it runs both outputs with independent random readiness, so partial acceptance happens on many beats. Round-robin alternation is forced by having two inputs each queue several back-to-back packets for one output, then reading the header source fields in the order they leave that output.

// File: rtl/pkt_port_switch.sv
module pkt_port_switch #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 3,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int IDW   = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<IDW)*N_OUT-1:0] route_tbl,
  input  logic [N_IN-1:0]        s_valid,
  output logic [N_IN-1:0]        s_ready,
  input  logic [N_IN*DW-1:0]     s_data,
  input  logic [N_IN-1:0]        s_last,
  output logic [N_OUT-1:0]       m_valid,
  input  logic [N_OUT-1:0]       m_ready,
  output logic [N_OUT*DW-1:0]    m_data,
  output logic [N_OUT-1:0]       m_last,
  output logic [N_IN-1:0]        err
);
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_HDR, S_FWD, S_DROP} st_t;

  logic [N_IN-1:0]  stg_v;
  logic [DW:0]      stg_d [N_IN];
  logic [DW:0]      mem   [N_IN][DEPTH];
  logic [PW-1:0]    wp [N_IN];
  logic [PW-1:0]    rp [N_IN];
  logic [CW-1:0]    cnt [N_IN];
  st_t              st [N_IN];
  logic [N_OUT-1:0] mask [N_IN];
  logic [N_OUT-1:0] sent [N_IN];
  logic [N_OUT-1:0] lock;
  logic [IW-1:0]    owner [N_OUT];
  logic [IW-1:0]    ptr;

  logic [DW:0]      head [N_IN];
  logic [N_OUT-1:0] rmask [N_IN];
  logic [N_OUT-1:0] owned [N_IN];
  logic [N_OUT-1:0] acc [N_IN];
  logic [N_OUT-1:0] gr [N_IN];
  logic [N_IN-1:0]  hv, hdr_ok, own_all, req, start, pop;
  logic [IW-1:0]    pick [N_OUT];
  logic [N_OUT-1:0] pick_v;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      head[i]    = mem[i][rp[i]];
      hv[i]      = cnt[i] != '0;
      s_ready[i] = (32'(cnt[i]) + 32'(stg_v[i])) < DEPTH;
      hdr_ok[i]  = ^head[i][DW-1:0];
      rmask[i]   = route_tbl[int'(head[i][IDW-1:0])*N_OUT +: N_OUT];
      for (int j = 0; j < N_OUT; j++)
        owned[i][j] = lock[j] && (owner[j] == IW'(i));
      own_all[i] = (st[i] == S_FWD) && ((mask[i] & ~owned[i]) == '0);
      req[i]     = (st[i] == S_FWD) && (owned[i] == '0);
    end
    for (int j = 0; j < N_OUT; j++) begin
      m_valid[j] = lock[j] && hv[owner[j]] && !sent[owner[j]][j];
      m_data[j*DW +: DW] = head[owner[j]][DW-1:0];
      m_last[j]  = head[owner[j]][DW];
      pick_v[j]  = 1'b0;
      pick[j]    = '0;
      for (int k = 0; k < N_IN; k++)
        if (!pick_v[j] && req[(int'(ptr) + k) % N_IN] && mask[(int'(ptr) + k) % N_IN][j]) begin
          pick_v[j] = 1'b1;
          pick[j]   = IW'((int'(ptr) + k) % N_IN);
        end
    end
    for (int i = 0; i < N_IN; i++) begin
      for (int j = 0; j < N_OUT; j++) begin
        acc[i][j] = owned[i][j] && m_valid[j] && m_ready[j];
        gr[i][j]  = !lock[j] && pick_v[j] && (pick[j] == IW'(i));
      end
      start[i] = req[i] && ((mask[i] & ~gr[i]) == '0);
      case (st[i])
        S_HDR:   pop[i] = hv[i] && (!hdr_ok[i] || rmask[i] == '0);
        S_FWD:   pop[i] = hv[i] && own_all[i] && (((sent[i] | acc[i]) & mask[i]) == mask[i]);
        default: pop[i] = hv[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_IN; i++)
      if (stg_v[i]) mem[i][wp[i]] <= stg_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v <= '0;
      lock  <= '0;
      ptr   <= '0;
      err   <= '0;
      for (int i = 0; i < N_IN; i++) begin
        stg_d[i] <= '0;
        wp[i]    <= '0;
        rp[i]    <= '0;
        cnt[i]   <= '0;
        st[i]    <= S_HDR;
        mask[i]  <= '0;
        sent[i]  <= '0;
      end
      for (int j = 0; j < N_OUT; j++) owner[j] <= '0;
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        stg_v[i] <= s_valid[i] && s_ready[i];
        if (s_valid[i] && s_ready[i]) stg_d[i] <= {s_last[i], s_data[i*DW +: DW]};
        if (stg_v[i]) wp[i] <= (32'(wp[i]) == DEPTH-1) ? '0 : wp[i] + 1'b1;
        if (pop[i])   rp[i] <= (32'(rp[i]) == DEPTH-1) ? '0 : rp[i] + 1'b1;
        cnt[i] <= cnt[i] + CW'(stg_v[i]) - CW'(pop[i]);
        case (st[i])
          S_HDR: if (hv[i]) begin
            if (!hdr_ok[i]) begin
              err[i] <= 1'b1;
              if (!head[i][DW]) st[i] <= S_DROP;
            end else if (rmask[i] == '0) begin
              if (!head[i][DW]) st[i] <= S_DROP;
            end else begin
              mask[i] <= rmask[i];
              sent[i] <= '0;
              st[i]   <= S_FWD;
            end
          end
          S_FWD: if (pop[i]) begin
            sent[i] <= '0;
            if (head[i][DW]) st[i] <= S_HDR;
          end else sent[i] <= sent[i] | acc[i];
          default: if (hv[i] && head[i][DW]) st[i] <= S_HDR;
        endcase
        if (start[i]) ptr <= IW'((i + 1) % N_IN);
      end
      for (int j = 0; j < N_OUT; j++) begin
        if (lock[j] && pop[owner[j]] && head[owner[j]][DW] && st[owner[j]] == S_FWD)
          lock[j] <= 1'b0;
        for (int i = 0; i < N_IN; i++)
          if (start[i] && mask[i][j]) begin
            lock[j]  <= 1'b1;
            owner[j] <= IW'(i);
          end
      end
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_chk
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid[j] && !m_ready[j] |=> m_valid[j] && $stable(m_data[j*DW +: DW]) && $stable(m_last[j]));
    assert_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid[j] && m_ready[j] && !m_last[j] |=> lock[j] && $stable(owner[j]));
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in_chk
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err[i] |=> err[i]);
    assert_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cnt[i]) + 32'(stg_v[i])) <= DEPTH);
    assert_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st[i] == S_FWD |-> (sent[i] & ~mask[i]) == '0);
  end
endmodule

// File: tb/test_pkt_port_switch.sv
`timescale 1ns/1ps
module test_pkt_port_switch;
  localparam int NI = 3;
  localparam int NO = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [32*NO-1:0] route_tbl;
  logic [NI-1:0]   s_valid, s_ready, s_last;
  logic [32*NI-1:0] s_data;
  logic [NO-1:0]   m_valid, m_ready, m_last;
  logic [32*NO-1:0] m_data;
  logic [NI-1:0]   err;

  always #10 clk = ~clk;

  pkt_port_switch i_pkt_port_switch (
    .clk(clk), .rst_n(rst_n), .route_tbl(route_tbl),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .err(err));

  int checks = 0, fails = 0;
  logic [32:0] expq [NO][NI][$];
  int          hdr_log [NO][$];
  int          rx_cnt [NO];
  int          acc_cnt [NI];
  int          rdy_mode [NO];
  logic [7:0]  pkt_no = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [31:0] mk_hdr(int src, int id, bit bad);
    logic [31:0] h;
    h = {1'b0, 3'b000, 7'd0, 5'(src), 1'b0, 3'd2, 7'd0, 5'(id)};
    h[31] = ~^h[30:0];
    if (bad) h[31] = ~h[31];
    return h;
  endfunction

  task automatic send_beat(int p, logic [31:0] d, bit l);
    @(negedge clk);
    s_valid[p] = 1'b1;
    s_data[p*32 +: 32] = d;
    s_last[p] = l;
    forever begin
      #5;
      if (s_ready[p]) begin
        @(posedge clk);
        acc_cnt[p]++;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic send_pkt(int p, int id, int len, bit bad);
    logic [NO-1:0] rt;
    logic [31:0]   w;
    logic [7:0]    n;
    rt = route_tbl[id*NO +: NO];
    n = pkt_no;
    pkt_no++;
    for (int b = 0; b < len; b++) begin
      w = (b == 0) ? mk_hdr(p, id, bad) : {8'(p), n, 16'(b)};
      if (!bad)
        for (int j = 0; j < NO; j++)
          if (rt[j]) expq[j][p].push_back({(b == len-1), w});
    end
    for (int b = 0; b < len; b++) begin
      w = (b == 0) ? mk_hdr(p, id, bad) : {8'(p), n, 16'(b)};
      send_beat(p, w, b == len-1);
    end
    @(negedge clk);
    s_valid[p] = 1'b0;
  endtask

  function automatic int pending();
    int t = 0;
    for (int j = 0; j < NO; j++)
      for (int p = 0; p < NI; p++) t += expq[j][p].size();
    return t;
  endfunction

  task automatic drain();
    for (int c = 0; c < 3000 && pending() != 0; c++) @(posedge clk);
    repeat (10) @(posedge clk);
  endtask

  // ready driver
  initial begin
    m_ready = '0;
    forever begin
      @(negedge clk);
      for (int j = 0; j < NO; j++)
        m_ready[j] = (rdy_mode[j] == 1) ? 1'b1 :
                     (rdy_mode[j] == 2) ? 1'($urandom_range(0, 1)) : 1'b0;
    end
  end

  // monitor and scoreboard
  initial begin
    bit in_pkt [NO];
    int cur [NO];
    logic [32:0] got, exp;
    for (int j = 0; j < NO; j++) begin in_pkt[j] = 0; cur[j] = 0; rx_cnt[j] = 0; end
    forever begin
      @(negedge clk);
      #5;
      if (rst_n)
        for (int j = 0; j < NO; j++)
          if (m_valid[j] && m_ready[j]) begin
            got = {m_last[j], m_data[j*32 +: 32]};
            rx_cnt[j]++;
            if (!in_pkt[j]) begin
              cur[j] = int'(got[20:16]);
              if (cur[j] >= NI) cur[j] = 0;
              hdr_log[j].push_back(cur[j]);
              in_pkt[j] = 1;
            end
            if (expq[j][cur[j]].size() == 0)
              chk(0, "R5", $sformatf("unexpected beat on out%0d", j), got, 0);
            else begin
              exp = expq[j][cur[j]].pop_front();
              chk(got == exp, "R2", $sformatf("beat on out%0d from in%0d (R1 header, R6 order)", j, cur[j]), got, exp);
            end
            if (got[32]) in_pkt[j] = 0;
          end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    report();
  end

  initial begin
    int c0, c1, a;
    logic [31:0] d0;
    rst_n = 1'b0;
    s_valid = '0; s_last = '0; s_data = '0;
    for (int j = 0; j < NO; j++) rdy_mode[j] = 1;
    for (int p = 0; p < NI; p++) acc_cnt[p] = 0;
    route_tbl = '0;
    route_tbl[1*NO +: NO] = 3'b001;
    route_tbl[2*NO +: NO] = 3'b010;
    route_tbl[3*NO +: NO] = 3'b101;
    route_tbl[4*NO +: NO] = 3'b111;
    route_tbl[5*NO +: NO] = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
    chk(m_valid == '0, "R10", "m_valid after reset", m_valid, 0);
    chk(err == '0, "R10", "err after reset", err, 0);
    chk(s_ready == '1, "R10", "s_ready after reset", s_ready, 7);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 unicast
    send_pkt(0, 1, 5, 0);
    drain();

    // R3 multicast and broadcast under random readiness
    for (int j = 0; j < NO; j++) rdy_mode[j] = 2;
    fork
      send_pkt(1, 3, 6, 0);
      send_pkt(2, 4, 4, 0);
    join
    drain();

    // R3 stalled destination holds the group
    rdy_mode[0] = 1; rdy_mode[1] = 1; rdy_mode[2] = 0;
    c0 = rx_cnt[0];
    fork
      send_pkt(0, 3, 3, 0);
      begin
        repeat (20) @(posedge clk);
        @(negedge clk); #5;
        chk(rx_cnt[0] - c0 == 1, "R3", "out0 beats while out2 stalled", rx_cnt[0] - c0, 1);
        rdy_mode[2] = 1;
      end
    join
    drain();

    // R5 no route
    c0 = rx_cnt[0] + rx_cnt[1] + rx_cnt[2];
    send_pkt(1, 5, 4, 0);
    send_pkt(1, 1, 2, 0);
    drain();
    c1 = rx_cnt[0] + rx_cnt[1] + rx_cnt[2];
    chk(c1 - c0 == 2, "R5", "beats out after unrouted + routed packet", c1 - c0, 2);
    chk(err == '0, "R5", "err after unrouted packet", err, 0);

    // R4 parity error, including single-beat header
    c0 = rx_cnt[1];
    send_pkt(2, 2, 3, 1);
    @(negedge clk); #5;
    chk(err == 3'b100, "R4", "err after bad parity", err, 4);
    send_pkt(2, 2, 1, 1);
    send_pkt(2, 2, 3, 0);
    drain();
    chk(rx_cnt[1] - c0 == 3, "R4", "out1 beats after dropped packets", rx_cnt[1] - c0, 3);
    chk(err == 3'b100, "R4", "err sticky", err, 4);

    // R7 R6 round-robin between two inputs on one output
    hdr_log[0].delete();
    rdy_mode[0] = 2;
    fork
      begin repeat (3) send_pkt(0, 1, 4, 0); end
      begin repeat (3) send_pkt(1, 1, 4, 0); end
    join
    drain();
    chk(hdr_log[0].size() == 6, "R7", "packets on out0", hdr_log[0].size(), 6);
    for (int k = 1; k < hdr_log[0].size(); k++)
      chk(hdr_log[0][k] != hdr_log[0][k-1], "R7", $sformatf("source alternation at packet %0d", k),
          hdr_log[0][k], 1 - hdr_log[0][k-1]);

    // R8 buffer depth, R9 stall hold
    rdy_mode[0] = 1; rdy_mode[1] = 0;
    a = acc_cnt[2];
    fork
      send_pkt(2, 2, 6, 0);
      begin
        repeat (20) @(posedge clk);
        @(negedge clk); #5;
        chk(acc_cnt[2] - a == 4, "R8", "beats taken with output blocked", acc_cnt[2] - a, 4);
        chk(s_ready[2] == 1'b0, "R8", "s_ready while full", s_ready[2], 0);
        chk(m_valid[1] == 1'b1, "R9", "m_valid held while stalled", m_valid[1], 1);
        d0 = m_data[32 +: 32];
        repeat (5) @(posedge clk);
        @(negedge clk); #5;
        chk(m_data[32 +: 32] == d0 && m_valid[1], "R9", "m_data held while stalled", m_data[32 +: 32], d0);
        rdy_mode[1] = 1;
      end
    join
    drain();

    for (int j = 0; j < NO; j++)
      for (int p = 0; p < NI; p++)
        chk(expq[j][p].size() == 0, "R2", $sformatf("undelivered beats out%0d in%0d", j, p),
            expq[j][p].size(), 0);
    report();
  end
endmodule